// File: doc/BRIEF.md
# Multi-mode streaming convolutional encoder

The block encodes a serial stream of information bits with one of four selectable convolutional codes. The codes cover two constraint lengths (7 and 9) and two rates (1/2 and 1/3). One bit enters per cycle under a valid/ready handshake. Coded bits leave on a fixed two-bit lane qualified by a valid strobe, and there is no backpressure on the output side. The port set is the same in every mode, so a rate-1/3 code passes its three bits per input through a small bit buffer that repacks them into two-bit beats. Input ready drops whenever that buffer could overflow.

A two-bit mode input picks the code. A change on that input takes effect only once the encoder is idle, and taking it clears the shift register. A one-cycle flush request terminates the trellis: the encoder shifts in K-1 zero bits, then empties the buffer. If a single coded bit is left over at the end, it goes out as a padded beat that is flagged on a dedicated output.

Top module: `conv_enc_multi`

## Requirements
- R1: After reset, out_valid and out_pad are low, the shift register holds all zeros, and in_ready is high while mode is 0.
- R2: The mode codes are: 0 = rate 1/2, K=9, generators 561 and 753 (octal); 1 = rate 1/3, K=9, generators 557, 663 and 711; 2 = rate 1/3, K=7, generators 133, 171 and 165; 3 = rate 1/2, K=7, generators 133 and 171. The most significant generator bit taps the current input bit, and the least significant bit taps the bit K-1 inputs earlier.
- R3: Coded bits leave in input order and, within one input, in generator order. Each beat carries the earlier bit on out_data[0] and the later bit on out_data[1]. In a rate-1/2 mode, a bit accepted at a clock edge produces its beat in the cycle that follows that edge.
- R4: In a rate-1/2 mode, in_ready stays high while running with a stable mode input, so one bit is taken every cycle.
- R5: In a rate-1/3 mode, in_ready is low whenever the buffer could not take three more bits after the current beat leaves. No coded bit is lost, and a continuous input of n bits is taken within n + (n-1)/2 + 1 cycles.
- R6: A flush request seen while running is accepted even when a data bit is taken in the same cycle; that data bit is encoded first. The encoder then appends K-1 zero inputs for the current mode, holds in_ready low, keeps emitting beats until the buffer is empty, and then accepts input again.
- R7: When one coded bit remains at the end of a termination, it leaves as a beat with out_data[1] = 0 and out_pad = 1. out_pad is low on every other beat.
- R8: While mode differs from the active mode, in_ready is low. The new mode is taken only while running with an empty buffer; until then, coding and any termination continue in the old mode. Taking a new mode clears the shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Requested code (see R2) |
| flush | input | 1 | Terminate the trellis and empty the buffer |
| in_valid | input | 1 | Information bit present |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Bit is taken when in_valid and in_ready are both high |
| out_valid | output | 1 | out_data holds a beat |
| out_data | output | 2 | Two coded bits, earlier bit in bit 0 |
| out_pad | output | 1 | This beat carries one real bit and a zero pad |

## Verification
The hardest case to reach is a mode request that arrives while one rate-1/3 bit is stranded in the buffer. With a single leftover bit, no beat can leave, so the new mode stays pending until a flush. To get there, the bench sends exactly one bit in a constraint-9 rate-1/3 mode and then raises a rate-1/2 mode on the input. It then confirms that ready stays low and that nothing more comes out. Finally it flushes and checks that the whole tail, including the padded last beat, follows the old code before the new mode takes over. A second sequence leaves data in the shift register without a flush, then switches modes and encodes an impulse. The impulse response then shows whether the register was cleared.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int KMAX = 9;
  localparam int NGEN = 3;
  localparam int SRW  = KMAX - 1;

  typedef enum logic [1:0] {
    MODE_R2K9 = 2'd0,
    MODE_R3K9 = 2'd1,
    MODE_R3K7 = 2'd2,
    MODE_R2K7 = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_TAIL  = 2'd1,
    ST_DRAIN = 2'd2
  } enc_state_e;

  // Short codes sit in the upper taps; the two oldest taps stay unused.
  function automatic logic [KMAX-1:0] short_taps(logic [6:0] g);
    return {g, 2'b00};
  endfunction

  function automatic logic [KMAX-1:0] gen_taps(mode_e m, int idx);
    logic [KMAX-1:0] t;
    t = '0;
    case (m)
      MODE_R2K9: t = (idx == 0) ? 9'o561 : (idx == 1) ? 9'o753 : '0;
      MODE_R3K9: t = (idx == 0) ? 9'o557 : (idx == 1) ? 9'o663 : 9'o711;
      MODE_R3K7: t = (idx == 0) ? short_taps(7'o133) :
                     (idx == 1) ? short_taps(7'o171) : short_taps(7'o165);
      default:   t = (idx == 0) ? short_taps(7'o133) :
                     (idx == 1) ? short_taps(7'o171) : '0;
    endcase
    return t;
  endfunction

  function automatic logic is_third(mode_e m);
    return (m == MODE_R3K9) || (m == MODE_R3K7);
  endfunction

  function automatic int unsigned tail_len(mode_e m);
    return ((m == MODE_R2K9) || (m == MODE_R3K9)) ? KMAX - 1 : 6;
  endfunction
endpackage

// File: rtl/conv_enc_core.sv
module conv_enc_core
  import conv_enc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  mode_e           mode,
  input  logic            step,
  input  logic            clear,
  input  logic            din,
  output logic [NGEN-1:0] code
);
  logic [SRW-1:0]  sr_q, sr_d;
  logic [KMAX-1:0] win;

  assign win = {din, sr_q};

  always_comb begin
    sr_d = sr_q;
    if (clear)     sr_d = '0;
    else if (step) sr_d = {din, sr_q[SRW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sr_q <= '0;
    else if (step || clear)  sr_q <= sr_d;
  end

  for (genvar g = 0; g < NGEN; g++) begin : g_par
    assign code[g] = ^(gen_taps(mode, g) & win);
  end
endmodule

// File: rtl/conv_enc_packer.sv
module conv_enc_packer #(
  parameter int CAP  = 4,
  parameter int NMAX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            wide,
  input  logic [NMAX-1:0] bits,
  input  logic            drain,
  output logic            out_valid,
  output logic [1:0]      out_data,
  output logic            out_pad,
  output logic            room_ok,
  output logic            empty
);
  localparam int CW = $clog2(CAP + 1);

  logic [CAP-1:0]  q_q, q_d;
  logic [CW-1:0]   cnt_q, cnt_d, popn, nin, left;
  logic [NMAX-1:0] bits_m;
  logic            pop2, pop1;

  always_comb begin
    pop2      = cnt_q >= CW'(2);
    pop1      = drain && (cnt_q == CW'(1));
    out_valid = pop2 || pop1;
    out_pad   = pop1 && !pop2;
    out_data  = pop2 ? q_q[1:0] : {1'b0, q_q[0]};
    popn      = pop2 ? CW'(2) : (pop1 ? CW'(1) : CW'(0));
    room_ok   = (CAP - int'(cnt_q) + int'(popn)) >= NMAX;
    empty     = cnt_q == '0;
    bits_m    = bits;
    if (!wide) bits_m[NMAX-1] = 1'b0;
    nin   = push ? (wide ? CW'(NMAX) : CW'(NMAX - 1)) : CW'(0);
    left  = cnt_q - popn;
    q_d   = (q_q >> popn);
    if (push) q_d = q_d | ({{(CAP-NMAX){1'b0}}, bits_m} << left);
    cnt_d = left + nin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      cnt_q <= '0;
    end else begin
      q_q   <= q_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/conv_enc_ctrl.sv
module conv_enc_ctrl
  import conv_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_req,
  input  logic  flush,
  input  logic  in_valid,
  input  logic  room_ok,
  input  logic  empty,
  output logic  in_ready,
  output logic  step,
  output logic  din_zero,
  output logic  clear,
  output logic  drain,
  output mode_e cur_mode
);
  localparam int TW = $clog2(KMAX);

  enc_state_e    st_q, st_d;
  logic [TW-1:0] tc_q, tc_d;
  mode_e         cur_q, cur_d;
  logic          match, take, tail_step;

  assign cur_mode = cur_q;

  always_comb begin
    match     = mode_req == cur_q;
    clear     = (st_q == ST_RUN) && !match && empty;
    in_ready  = (st_q == ST_RUN) && match && room_ok;
    take      = in_valid && in_ready;
    tail_step = (st_q == ST_TAIL) && room_ok;
    step      = take || tail_step;
    din_zero  = st_q == ST_TAIL;
    drain     = st_q == ST_DRAIN;
    st_d  = st_q;
    tc_d  = tc_q;
    cur_d = cur_q;
    case (st_q)
      ST_RUN: begin
        if (clear) begin
          cur_d = mode_req;
        end else if (flush) begin
          st_d = ST_TAIL;
          tc_d = TW'(tail_len(cur_q));
        end
      end
      ST_TAIL: begin
        if (tail_step) begin
          tc_d = tc_q - TW'(1);
          if (tc_q == TW'(1)) st_d = ST_DRAIN;
        end
      end
      default: begin
        if (empty) st_d = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      tc_q  <= '0;
      cur_q <= MODE_R2K9;
    end else begin
      st_q  <= st_d;
      tc_q  <= tc_d;
      cur_q <= cur_d;
    end
  end
endmodule

// File: rtl/conv_enc_multi.sv
module conv_enc_multi
  import conv_enc_pkg::*;
#(
  parameter int BUF_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       flush,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       out_valid,
  output logic [1:0] out_data,
  output logic       out_pad
);
  mode_e            cur_mode;
  logic             step, din_zero, clear, drain, room_ok, empty, din;
  logic [NGEN-1:0]  code;

  assign din = din_zero ? 1'b0 : in_bit;

  conv_enc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_e'(mode)), .flush(flush),
    .in_valid(in_valid), .room_ok(room_ok), .empty(empty),
    .in_ready(in_ready), .step(step), .din_zero(din_zero), .clear(clear),
    .drain(drain), .cur_mode(cur_mode)
  );

  conv_enc_core u_core (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode), .step(step), .clear(clear),
    .din(din), .code(code)
  );

  conv_enc_packer #(.CAP(BUF_BITS), .NMAX(NGEN)) u_pack (
    .clk(clk), .rst_n(rst_n), .push(step), .wide(is_third(cur_mode)),
    .bits(code), .drain(drain), .out_valid(out_valid), .out_data(out_data),
    .out_pad(out_pad), .room_ok(room_ok), .empty(empty)
  );
endmodule

// File: rtl/conv_enc_multi_chk.sv
module conv_enc_multi_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       flush,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_hi,
  input logic       out_pad,
  input logic [1:0] cur_mode
);
  logic half;
  assign half = (cur_mode == 2'd0) || (cur_mode == 2'd3);

  AST_PAD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    out_pad |-> (out_valid && !out_hi));                                   // R7
  AST_HALF_NEXT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && half) |=> out_valid);                         // R3
  AST_HALF_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !flush && half) |=> (in_ready || !$stable(mode)));        // R4
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && in_ready) |=> !in_ready);                                    // R6
  AST_NO_READY_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != cur_mode) |-> !in_ready);                                     // R8
  AST_MODE_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_mode) |-> (!$past(out_valid) && ($past(mode) == cur_mode))); // R8
endmodule

bind conv_enc_multi conv_enc_multi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .flush(flush), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_hi(out_data[1]),
  .out_pad(out_pad), .cur_mode(cur_mode)
);

// File: tb/tb_conv_enc_multi.sv
module tb_conv_enc_multi;
  logic clk, rst_n, flush, in_valid, in_bit;
  logic [1:0] mode, out_data;
  logic in_ready, out_valid, out_pad;

  int nchk, nfail, cycles, exp_n, got_n;
  bit dat [0:127];
  bit sbits [0:1023];
  logic [1:0] exp_d [0:511];
  bit exp_p [0:511];

  conv_enc_multi dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .flush(flush), .in_valid(in_valid),
    .in_bit(in_bit), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_pad(out_pad)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (got_n < exp_n) begin
        check(out_data == exp_d[got_n], "R2,R3 beat", int'(out_data), int'(exp_d[got_n]));
        check(out_pad == exp_p[got_n], "R7 pad flag", int'(out_pad), int'(exp_p[got_n]));
      end else begin
        check(1'b0, "R6 extra beat", got_n, exp_n);
      end
      got_n++;
    end
  end

  function automatic int gen_of(int m, int g);
    case (m)
      0: return (g == 0) ? 'o561 : 'o753;
      1: return (g == 0) ? 'o557 : (g == 1) ? 'o663 : 'o711;
      2: return (g == 0) ? 'o133 : (g == 1) ? 'o171 : 'o165;
      default: return (g == 0) ? 'o133 : 'o171;
    endcase
  endfunction

  task automatic make_pat(input int kind, input int n, input int seed);
    int lf = seed;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: dat[i] = (i == 0);
        1: dat[i] = 1'b1;
        default: begin
          dat[i] = lf[0];
          lf = (lf >> 1) ^ ((lf & 1) != 0 ? 'hB400 : 0);
        end
      endcase
    end
  endtask

  // Expected stream from the code definitions (R2), packed per R3, padded per R7.
  task automatic build(input int m, input int n, input bit tail);
    int k  = (m < 2) ? 9 : 7;
    int nb = (m == 1 || m == 2) ? 3 : 2;
    int len = n + (tail ? k - 1 : 0);
    int sl = 0;
    for (int t = 0; t < len; t++) begin
      for (int g = 0; g < nb; g++) begin
        bit x = 1'b0;
        for (int i = 0; i < k; i++)
          if (t - i >= 0 && t - i < n && ((gen_of(m, g) >> (k - 1 - i)) & 1) != 0)
            x ^= dat[t - i];
        sbits[sl] = x;
        sl++;
      end
    end
    exp_n = (sl + 1) / 2;
    for (int b = 0; b < exp_n; b++) begin
      exp_d[b][0] = sbits[2*b];
      exp_d[b][1] = (2*b + 1 < sl) ? sbits[2*b+1] : 1'b0;
      exp_p[b]    = (2*b + 1 >= sl);
    end
    got_n = 0;
  endtask

  task automatic send_bits(input int n, input bit wf, output int cyc, output bit lowseen);
    int k = 0;
    bit tk;
    cyc = 0;
    lowseen = 1'b0;
    while (k < n) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = dat[k];
      flush    = wf && (k == n - 1);
      tk = in_ready;
      if (!tk) lowseen = 1'b1;
      @(posedge clk);
      cyc++;
      if (tk) k++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    flush    = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int lim = 0;
    while (got_n < exp_n && lim < 600) begin
      @(negedge clk);
      lim++;
    end
    repeat (5) @(negedge clk);
    check(got_n == exp_n, req, got_n, exp_n);
    check(in_ready == 1'b1, "R6 ready after end", int'(in_ready), 1);
  endtask

  task automatic set_mode(input int m);
    int lim = 0;
    @(negedge clk);
    mode = 2'(m);
    #1;
    check(in_ready == 1'b0, "R8 ready low on mode mismatch", int'(in_ready), 0);
    while (!in_ready && lim < 20) begin
      @(negedge clk);
      lim++;
    end
    check(in_ready == 1'b1, "R8 new mode taken when idle", int'(in_ready), 1);
  endtask

  task automatic run_case(input int m, input int kind, input int n, input int seed);
    int cyc;
    bit low;
    make_pat(kind, n, seed);
    build(m, n, 1'b1);
    send_bits(n, 1'b0, cyc, low);
    if (m == 0 || m == 3) begin
      check(cyc == n, "R4 full rate", cyc, n);
    end else begin
      check(cyc <= n + (n - 1) / 2 + 1, "R5 throughput", cyc, n + (n - 1) / 2 + 1);
      if (n > 3) check(low, "R5 ready throttles", int'(low), 1);
    end
    do_flush();
    wait_done("R6 terminated beat count");
  endtask

  initial begin
    int cyc;
    bit low;
    nchk = 0; nfail = 0; cycles = 0; exp_n = 0; got_n = 0;
    rst_n = 1'b0; mode = 2'd0; flush = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(out_pad == 1'b0, "R1 out_pad after reset", int'(out_pad), 0);
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

    // Mode 0: impulse first, with R3 beat timing.
    make_pat(0, 1, 0);
    build(0, 1, 1'b1);
    send_bits(1, 1'b0, cyc, low);
    check(out_valid == 1'b1, "R3 beat in cycle after accept", int'(out_valid), 1);
    do_flush();
    wait_done("R1 zero start impulse mode 0");
    run_case(0, 1, 12, 0);
    run_case(0, 2, 33, 'h1d3);
    // R6: flush together with the last data bit.
    make_pat(2, 10, 'h2a5);
    build(0, 10, 1'b1);
    send_bits(10, 1'b1, cyc, low);
    wait_done("R6 flush with last bit");

    // Mode 1 (rate 1/3, K=9).
    set_mode(1);
    run_case(1, 0, 1, 0);
    run_case(1, 1, 8, 0);
    run_case(1, 2, 41, 'h3c1);

    // R8: request mode 3 while one coded bit sits in the buffer.
    make_pat(1, 1, 0);
    build(1, 1, 1'b1);
    send_bits(1, 1'b0, cyc, low);
    mode = 2'd3;
    #1;
    check(in_ready == 1'b0, "R8 pending mode blocks input", int'(in_ready), 0);
    repeat (6) @(negedge clk);
    check(got_n == 1, "R8 stranded bit held", got_n, 1);
    check(in_ready == 1'b0, "R8 mode still pending", int'(in_ready), 0);
    do_flush();
    wait_done("R8 tail in old mode");

    // Mode 3 (rate 1/2, K=7).
    run_case(3, 0, 1, 0);
    run_case(3, 2, 30, 'h0f7);
    make_pat(2, 9, 'h155);
    build(3, 9, 1'b0);
    send_bits(9, 1'b0, cyc, low);
    wait_done("R3 unterminated beats");

    // R8: switching to mode 2 clears the leftover register contents.
    set_mode(2);
    run_case(2, 0, 1, 0);
    run_case(2, 2, 50, 'h2e9);
    run_case(2, 2, 7, 'h0b3);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule